// File: doc/BRIEF.md
# Instruction Row Placer

This block maps a stream of decoded instructions onto a two-dimensional grid of ALU cells. Instructions arrive one per cycle in program order. Each one names a destination register, up to two source registers, and says whether it is a conditional branch. The column of a normal instruction is its destination register. The row is the highest one that still respects data flow from north to south.

Across a configuration phase the placer keeps four kinds of state. Per column it holds the level of the latest writer and the deepest reader. It also holds the deepest occupied level in the grid and a barrier level left by the last branch. A branch always lands below everything placed so far, and nothing after it may rise to or above its row.

When an instruction cannot fit in the grid, the placer refuses it and raises `full`. The front end then starts a new phase with `clear`. It does the same to restart decoding at a loop target, so the target lands in row 0.

Top module: `row_placer`

## Requirements
- R1: After reset `full` and `out_valid` are low and `in_ready` is high.
- R2: An instruction whose enabled sources were never written in the current phase, and whose destination column is empty, goes to row 0.
- R3: A normal instruction is reported in the column equal to its destination register. A branch is reported with `out_col` = 0 and `out_branch` = 1, and its destination field has no effect on the column state.
- R4: An instruction reading a register last written in row r, with no other constraint, is placed in row r+1.
- R5: With two enabled sources, the row is one below the deeper of the two writers.
- R6: An instruction is never placed at or above the latest writer of its own destination column; it goes at least one row below it.
- R7: An instruction is never placed above the deepest row that reads its destination register (same row is allowed, since a cell reads the previous row).
- R8: A branch is placed one row below the deepest occupied row of the grid, or lower if its sources require it.
- R9: Every instruction after a branch is placed strictly below the branch's row.
- R10: If the computed row exceeds ROWS-1, `in_ready` is low and the instruction is not taken. `full` rises on the next cycle and stays high, with `in_ready` low, until `clear`.
- R11: `clear` drops all tracking state and `full`; it blocks acceptance in its own cycle, and the next independent instruction goes to row 0.
- R12: `out_valid` rises in the cycle after an accepted transfer (`in_valid` and `in_ready` high at a clock edge) and at no other time. It carries that instruction's row, column and branch flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Start a new placement phase |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction will be taken at this edge |
| in_branch | input | 1 | Instruction is a conditional branch |
| in_dst | input | $clog2(NREGS) | Destination register |
| in_src1_en | input | 1 | First source used |
| in_src1 | input | $clog2(NREGS) | First source register |
| in_src2_en | input | 1 | Second source used |
| in_src2 | input | $clog2(NREGS) | Second source register |
| out_valid | output | 1 | Placement result present |
| out_branch | output | 1 | Placed instruction was a branch |
| out_row | output | $clog2(ROWS) | Assigned row |
| out_col | output | $clog2(NREGS) | Assigned column |
| full | output | 1 | Grid cannot take the pending instruction |

## Verification
The bench runs a summing loop and checks several ordering hazards:
- Every row after a branch must sit below the branch. A placer that forgot the barrier would lift an independent instruction above it.
- A column overwritten after a deep read must not let the new writer rise above that reader. A design that tracked only writers would put it in row 1 instead of row 3.
- An instruction that is refused when the grid overflows must not be counted. If it were, `out_valid` would pulse and `full` would fail to hold.
- After `clear`, a source written in the old phase must no longer push placement down.

// File: rtl/row_placer_pkg.sv
package row_placer_pkg;
  localparam int unsigned DEF_NREGS = 8;
  localparam int unsigned DEF_ROWS  = 8;

  typedef enum logic {
    KIND_ALU    = 1'b0,
    KIND_BRANCH = 1'b1
  } instr_kind_e;
endpackage

// File: rtl/placer_col_track.sv
module placer_col_track #(
  parameter int unsigned NREGS = 8,
  parameter int unsigned LW    = 4,
  localparam int unsigned CW   = $clog2(NREGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       upd_en,
  input  logic [CW-1:0]              upd_dst,
  input  logic [LW-1:0]              upd_lvl,
  input  logic                       rd1_en,
  input  logic [CW-1:0]              rd1,
  input  logic                       rd2_en,
  input  logic [CW-1:0]              rd2,
  output logic [NREGS-1:0][LW-1:0]   wlvl,
  output logic [NREGS-1:0][LW-1:0]   rlvl
);
  for (genvar j = 0; j < NREGS; j++) begin : g_col
    logic [LW-1:0] w_q, w_d, r_q, r_d;
    logic          hit_w, hit_r;

    assign hit_w = upd_en && (upd_dst == CW'(j));
    assign hit_r = upd_en && ((rd1_en && rd1 == CW'(j)) ||
                              (rd2_en && rd2 == CW'(j)));

    always_comb begin
      w_d = w_q;
      r_d = r_q;
      if (clear) begin
        w_d = '0;
        r_d = '0;
      end else begin
        if (hit_w) w_d = upd_lvl;
        if (hit_r && (upd_lvl > r_q)) r_d = upd_lvl;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        w_q <= '0;
        r_q <= '0;
      end else begin
        w_q <= w_d;
        r_q <= r_d;
      end
    end

    assign wlvl[j] = w_q;
    assign rlvl[j] = r_q;
  end
endmodule

// File: rtl/placer_row_calc.sv
module placer_row_calc #(
  parameter int unsigned NREGS = 8,
  parameter int unsigned ROWS  = 8,
  parameter int unsigned LW    = 4,
  localparam int unsigned CW   = $clog2(NREGS)
) (
  input  logic [NREGS-1:0][LW-1:0] wlvl,
  input  logic [NREGS-1:0][LW-1:0] rlvl,
  input  logic [LW-1:0]            blvl,
  input  logic [LW-1:0]            dlvl,
  input  logic                     is_branch,
  input  logic [CW-1:0]            dst,
  input  logic                     src1_en,
  input  logic [CW-1:0]            src1,
  input  logic                     src2_en,
  input  logic [CW-1:0]            src2,
  output logic [LW-1:0]            row_raw,
  output logic                     fits
);
  localparam logic [LW-1:0] LAST_ROW = LW'(ROWS - 1);

  function automatic logic [LW-1:0] lmax(input logic [LW-1:0] a, input logic [LW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [LW-1:0] l_s1, l_s2, l_waw, l_war, l_dep;

  always_comb begin
    l_s1  = src1_en ? wlvl[src1] : '0;
    l_s2  = src2_en ? wlvl[src2] : '0;
    l_waw = wlvl[dst];
    l_war = (rlvl[dst] != '0) ? (rlvl[dst] - LW'(1)) : '0;
    l_dep = lmax(lmax(l_s1, l_s2), blvl);
    if (is_branch) row_raw = lmax(l_dep, dlvl);
    else           row_raw = lmax(l_dep, lmax(l_waw, l_war));
    fits = (row_raw <= LAST_ROW);
  end
endmodule

// File: rtl/placer_phase.sv
module placer_phase #(
  parameter int unsigned LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          acc,
  input  logic          acc_branch,
  input  logic [LW-1:0] acc_lvl,
  input  logic          overflow,
  output logic [LW-1:0] blvl,
  output logic [LW-1:0] dlvl,
  output logic          full
);
  logic [LW-1:0] blvl_d, dlvl_d;
  logic          full_d;

  always_comb begin
    blvl_d = blvl;
    dlvl_d = dlvl;
    full_d = full;
    if (clear) begin
      blvl_d = '0;
      dlvl_d = '0;
      full_d = 1'b0;
    end else begin
      if (acc && acc_lvl > dlvl) dlvl_d = acc_lvl;
      if (acc && acc_branch)     blvl_d = acc_lvl;
      if (overflow)              full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blvl <= '0;
      dlvl <= '0;
      full <= 1'b0;
    end else begin
      blvl <= blvl_d;
      dlvl <= dlvl_d;
      full <= full_d;
    end
  end
endmodule

// File: rtl/row_placer.sv
module row_placer
  import row_placer_pkg::*;
#(
  parameter int unsigned NREGS = DEF_NREGS,
  parameter int unsigned ROWS  = DEF_ROWS,
  localparam int unsigned CW   = $clog2(NREGS),
  localparam int unsigned RW   = $clog2(ROWS),
  localparam int unsigned LW   = $clog2(ROWS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_branch,
  input  logic [CW-1:0] in_dst,
  input  logic          in_src1_en,
  input  logic [CW-1:0] in_src1,
  input  logic          in_src2_en,
  input  logic [CW-1:0] in_src2,
  output logic          out_valid,
  output logic          out_branch,
  output logic [RW-1:0] out_row,
  output logic [CW-1:0] out_col,
  output logic          full
);
  logic [1:0] rst_sync;
  logic       live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign live = rst_sync[1];

  logic [NREGS-1:0][LW-1:0] wlvl, rlvl;
  logic [LW-1:0]            blvl, dlvl, row_raw, acc_lvl;
  logic                     fits, acc, overflow;
  instr_kind_e              kind;

  assign kind     = in_branch ? KIND_BRANCH : KIND_ALU;
  assign in_ready = live && !clear && !full && fits;
  assign acc      = in_valid && in_ready;
  assign overflow = live && in_valid && !fits;
  assign acc_lvl  = row_raw + LW'(1);

  placer_row_calc #(.NREGS(NREGS), .ROWS(ROWS), .LW(LW)) u_calc (
    .wlvl(wlvl), .rlvl(rlvl), .blvl(blvl), .dlvl(dlvl),
    .is_branch(kind == KIND_BRANCH), .dst(in_dst),
    .src1_en(in_src1_en), .src1(in_src1),
    .src2_en(in_src2_en), .src2(in_src2),
    .row_raw(row_raw), .fits(fits)
  );

  placer_col_track #(.NREGS(NREGS), .LW(LW)) u_cols (
    .clk(clk), .rst_n(rst_n), .clear(clear || !live),
    .upd_en(acc && kind == KIND_ALU), .upd_dst(in_dst), .upd_lvl(acc_lvl),
    .rd1_en(in_src1_en), .rd1(in_src1), .rd2_en(in_src2_en), .rd2(in_src2),
    .wlvl(wlvl), .rlvl(rlvl)
  );

  placer_phase #(.LW(LW)) u_phase (
    .clk(clk), .rst_n(rst_n), .clear(clear || !live),
    .acc(acc), .acc_branch(kind == KIND_BRANCH), .acc_lvl(acc_lvl),
    .overflow(overflow), .blvl(blvl), .dlvl(dlvl), .full(full)
  );

  logic          ov_d, ob_d;
  logic [RW-1:0] or_d;
  logic [CW-1:0] oc_d;

  always_comb begin
    ov_d = acc;
    ob_d = out_branch;
    or_d = out_row;
    oc_d = out_col;
    if (acc) begin
      ob_d = (kind == KIND_BRANCH);
      or_d = row_raw[RW-1:0];
      oc_d = (kind == KIND_BRANCH) ? '0 : in_dst;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_branch <= 1'b0;
      out_row    <= '0;
      out_col    <= '0;
    end else begin
      out_valid  <= ov_d;
      out_branch <= ob_d;
      out_row    <= or_d;
      out_col    <= oc_d;
    end
  end
endmodule

// File: rtl/row_placer_chk.sv
module row_placer_chk (
  input logic clk,
  input logic rst_n,
  input logic clear,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic full
);
  // R10
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !in_ready);

  // R10
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clear) |=> full);

  // R11
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!full && !out_valid));

  // R12
  out_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R12
  out_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready));
endmodule

bind row_placer row_placer_chk u_row_placer_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .full(full)
);

// File: tb/test_row_placer.sv
module test_row_placer;
  localparam int CLK_PERIOD = 10;
  localparam int NREGS = 8;
  localparam int ROWS  = 8;
  localparam int CW = $clog2(NREGS);
  localparam int RW = $clog2(ROWS);
  localparam int NV = 22;

  typedef struct packed {
    logic          clr;
    logic          br;
    logic [CW-1:0] dst;
    logic          s1en;
    logic [CW-1:0] s1;
    logic          s2en;
    logic [CW-1:0] s2;
    logic [RW-1:0] row;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0},
    '{1'b0, 1'b0, 3'd1, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0},
    '{1'b0, 1'b0, 3'd2, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0},
    '{1'b0, 1'b0, 3'd3, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0},
    '{1'b0, 1'b0, 3'd4, 1'b1, 3'd2, 1'b0, 3'd0, 3'd1},
    '{1'b0, 1'b0, 3'd3, 1'b1, 3'd3, 1'b1, 3'd4, 3'd2},
    '{1'b0, 1'b0, 3'd2, 1'b1, 3'd2, 1'b0, 3'd0, 3'd1},
    '{1'b0, 1'b0, 3'd1, 1'b1, 3'd1, 1'b0, 3'd0, 3'd1},
    '{1'b0, 1'b1, 3'd5, 1'b1, 3'd1, 1'b0, 3'd0, 3'd3},
    '{1'b0, 1'b0, 3'd3, 1'b1, 3'd1, 1'b1, 3'd3, 3'd4},
    '{1'b0, 1'b0, 3'd5, 1'b0, 3'd0, 1'b0, 3'd0, 3'd4},
    '{1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0},
    '{1'b0, 1'b0, 3'd6, 1'b1, 3'd5, 1'b0, 3'd0, 3'd0},
    '{1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0},
    '{1'b0, 1'b0, 3'd2, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0},
    '{1'b0, 1'b0, 3'd2, 1'b1, 3'd2, 1'b0, 3'd0, 3'd1},
    '{1'b0, 1'b0, 3'd2, 1'b1, 3'd2, 1'b0, 3'd0, 3'd2},
    '{1'b0, 1'b0, 3'd3, 1'b1, 3'd0, 1'b1, 3'd2, 3'd3},
    '{1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd3},
    '{1'b0, 1'b0, 3'd2, 1'b0, 3'd0, 1'b0, 3'd0, 3'd3},
    '{1'b0, 1'b0, 3'd7, 1'b1, 3'd6, 1'b0, 3'd0, 3'd1},
    '{1'b0, 1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 3'd4}
  };

  function automatic string tag_of(input int i);
    case (i)
      1, 2, 3, 13, 14: return "R2";
      4, 6, 7, 15, 16, 20: return "R4";
      5, 17: return "R5";
      8, 21: return "R8";
      9, 10: return "R9";
      12: return "R11";
      18: return "R7";
      19: return "R6";
      default: return "R2";
    endcase
  endfunction

  logic clk, rst_n, clear, in_valid, in_ready, in_branch;
  logic [CW-1:0] in_dst, in_src1, in_src2, out_col;
  logic in_src1_en, in_src2_en, out_valid, out_branch, full;
  logic [RW-1:0] out_row;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  row_placer #(.NREGS(NREGS), .ROWS(ROWS)) i_row_placer (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
    .in_ready(in_ready), .in_branch(in_branch), .in_dst(in_dst),
    .in_src1_en(in_src1_en), .in_src1(in_src1),
    .in_src2_en(in_src2_en), .in_src2(in_src2),
    .out_valid(out_valid), .out_branch(out_branch), .out_row(out_row),
    .out_col(out_col), .full(full)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic br, input logic [CW-1:0] dst,
                       input logic s1en, input logic [CW-1:0] s1,
                       input logic s2en, input logic [CW-1:0] s2);
    in_valid = 1'b1; in_branch = br; in_dst = dst;
    in_src1_en = s1en; in_src1 = s1; in_src2_en = s2en; in_src2 = s2;
  endtask

  task automatic place(input logic br, input logic [CW-1:0] dst,
                       input logic s1en, input logic [CW-1:0] s1,
                       input logic s2en, input logic [CW-1:0] s2,
                       input logic [RW-1:0] exp_row, input string req);
    @(negedge clk);
    drive(br, dst, s1en, s1, s2en, s2);
    #1;
    check(in_ready == 1'b1, "R10", "in_ready", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R12", "out_valid", int'(out_valid), 1);
    check(out_row == exp_row, req, "out_row", int'(out_row), int'(exp_row));
    check(out_col == (br ? '0 : dst), "R3", "out_col", int'(out_col),
          br ? 0 : int'(dst));
    check(out_branch == br, "R12", "out_branch", int'(out_branch), int'(br));
  endtask

  task automatic do_clear();
    @(negedge clk);
    in_valid = 1'b0;
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check(full == 1'b0, "R11", "full after clear", int'(full), 0);
    check(out_valid == 1'b0, "R11", "out_valid after clear", int'(out_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clear = 1'b0;
    in_valid = 1'b0; in_branch = 1'b0; in_dst = '0;
    in_src1_en = 1'b0; in_src1 = '0; in_src2_en = 1'b0; in_src2 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: idle state after reset
    check(full == 1'b0, "R1", "full", int'(full), 0);
    check(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].clr) do_clear();
      else place(VECS[i].br, VECS[i].dst, VECS[i].s1en, VECS[i].s1,
                 VECS[i].s2en, VECS[i].s2, VECS[i].row, tag_of(i));
    end

    // R10: fill column 0 with a dependence chain down to the last row
    do_clear();
    for (int r = 0; r < ROWS; r++)
      place(1'b0, 3'd0, (r != 0), 3'd0, 1'b0, 3'd0, RW'(r), "R4");
    @(negedge clk);
    drive(1'b0, 3'd0, 1'b1, 3'd0, 1'b0, 3'd0);
    #1;
    check(in_ready == 1'b0, "R10", "in_ready on overflow", int'(in_ready), 0);
    @(negedge clk);
    check(full == 1'b1, "R10", "full raised", int'(full), 1);
    check(out_valid == 1'b0, "R10", "refused not emitted", int'(out_valid), 0);
    drive(1'b0, 3'd5, 1'b0, 3'd0, 1'b0, 3'd0);
    #1;
    check(in_ready == 1'b0, "R10", "in_ready while full", int'(in_ready), 0);
    @(negedge clk);
    check(full == 1'b1, "R10", "full held", int'(full), 1);
    check(out_valid == 1'b0, "R10", "no output while full", int'(out_valid), 0);
    in_valid = 1'b0;

    // R11: a restart phase puts the held instruction back at row 0
    do_clear();
    place(1'b0, 3'd0, 1'b1, 3'd0, 1'b0, 3'd0, '0, "R11");

    // R11: clear cycle itself refuses input
    @(negedge clk);
    drive(1'b0, 3'd4, 1'b0, 3'd0, 1'b0, 3'd0);
    clear = 1'b1;
    #1;
    check(in_ready == 1'b0, "R11", "in_ready during clear", int'(in_ready), 0);
    @(negedge clk);
    clear = 1'b0;
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R11", "no output from clear cycle", int'(out_valid), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule